// File: doc/BRIEF.md
# Session Request Control and Status Register

This block is one byte-wide register that a USB device controller uses to run the session request protocol as a B-device. Firmware reads the register directly and writes it with a single strobe and data byte. There is no address. The register holds three control bits: data-line pulsing, VBUS pulsing and VBUS discharge. These bits drive the matching pins toward the analog front end. A master enable bit gates all three control outputs. While that enable is clear, the block asks the normal VBUS sensing path to stay active.

The register also holds two sticky status flags, fed from comparator inputs.

- The session-valid flag records that VBUS has crossed the B-device session-valid threshold.
- The initial-condition flag records any moment when VBUS was not below 0.8 V or the data lines were not at SE0.

Both flags pass through a two-flop synchronizer first. Both clear only when a 1 is written to them, and they come back while their cause remains.

A millisecond tick drives a small timer that measures each VBUS pulse. A pulse that is too short or too long raises a separate sticky error output.

Top module: `srp_ctrl_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x00, the three drive outputs are low, `vbus_sense_en_o` is high and `pw_err_o` is low.
- R2: Bit 0 (enable), bit 1 (VBUS pulse), bit 2 (discharge) and bit 5 (data-line pulse) take the written value on a write. Bits 7 and 6 always read 0, whatever is written to them.
- R3: While bit 0 is 0, `dline_pulse_o`, `vbus_pulse_o` and `vbus_dischg_o` are 0 whatever the other bits hold. `vbus_sense_en_o` is the inverse of bit 0.
- R4: While bit 0 is 1, `dline_pulse_o` follows bit 5, `vbus_pulse_o` follows bit 1 and `vbus_dischg_o` follows bit 2.
- R5: Bit 4 becomes 1 within four clocks of `vbus_sess_vld_i` going high. It stays 1 after that input falls.
- R6: Writing 1 to bit 4 clears it once the session-valid input has been low for at least three clocks. Writing 0 to bit 4 leaves it unchanged.
- R7: A write of 1 to bit 4 while session-valid is still high leaves bit 4 at 1.
- R8: Bit 3 is set whenever `vbus_low_i` is 0 or `line_se0_i` is 0 (after synchronization). Only a write of 1 clears it, and that write has no effect while the violation persists.
- R9: A VBUS pulse whose length is at most MIN_MS ticks sets `pw_err_o` once the pulse ends. Length means the ticks counted while `vbus_pulse_o` is high.
- R10: A VBUS pulse that ends after more than MIN_MS and fewer than MAX_MS ticks leaves `pw_err_o` low.
- R11: `pw_err_o` goes high while the pulse is still high, on the tick that brings its count to MAX_MS.
- R12: `pw_err_o` is sticky until a new VBUS pulse starts. The start of a new pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Live register contents |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| vbus_sess_vld_i | input | 1 | Comparator: VBUS above session-valid threshold |
| vbus_low_i | input | 1 | Comparator: VBUS below 0.8 V |
| line_se0_i | input | 1 | Both data lines at SE0 |
| dline_pulse_o | output | 1 | Data-line pulse drive |
| vbus_pulse_o | output | 1 | VBUS pulse drive |
| vbus_dischg_o | output | 1 | VBUS discharge drive |
| vbus_sense_en_o | output | 1 | Normal VBUS sensing allowed |
| pw_err_o | output | 1 | Sticky VBUS pulse-width error |

## Verification
The bench builds the block with its default window of MIN_MS = 16 and MAX_MS = 26 and a two-stage synchronizer. It supplies the millisecond tick itself, one tick per clock when it wants one. With that tick rate, pulses of 10, 16, 17, 20, 25 and 26 ticks each fit in a few dozen cycles. Both edges of the window can therefore be checked exactly: the count at which a pulse stops being short, and the count at which a long pulse is flagged while still high.

// File: rtl/srp_pkg.sv
package srp_pkg;

    // Bit positions seen by firmware
    localparam int BIT_EN    = 0;
    localparam int BIT_VP    = 1;
    localparam int BIT_DIS   = 2;
    localparam int BIT_INIT  = 3;
    localparam int BIT_BSESS = 4;
    localparam int BIT_DP    = 5;
    localparam int REG_W     = 8;
    localparam int USED_W    = 6;

    // Field order matches bits 5..0 so the struct maps straight onto the byte
    typedef struct packed {
        logic dpulse;
        logic bsess;
        logic init_v;
        logic dischg;
        logic vpulse;
        logic en;
    } srp_regs_t;

    // Synchronized status inputs
    typedef struct packed {
        logic se0;
        logic vlow;
        logic sess;
    } srp_sense_t;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int W       = 3,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stage_d;
    logic [STAGES-1:0][W-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = async_i;
            end else begin : g_rest
                always_comb stage_d[g] = stage_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/srp_pw_timer.sv
module srp_pw_timer #(
    parameter int MIN_MS = 16,
    parameter int MAX_MS = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic tick_i,
    output logic err_o
);

    localparam int CNT_W = $clog2(MAX_MS + 1);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_MS);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_MS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             act;
        logic             err;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.act = active_i;
        if (active_i && !tmr_q.act) begin
            // new pulse: restart measurement, drop old error
            tmr_d.cnt = '0;
            tmr_d.err = 1'b0;
        end else if (active_i) begin
            if (tick_i && (tmr_q.cnt < MAX_C)) begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
            if (tmr_d.cnt >= MAX_C) begin
                tmr_d.err = 1'b1;
            end
        end else if (tmr_q.act) begin
            // pulse just ended
            if (tmr_q.cnt <= MIN_C) begin
                tmr_d.err = 1'b1;
            end
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign err_o = tmr_q.err;

endmodule

// File: rtl/srp_ctrl_reg.sv
module srp_ctrl_reg #(
    parameter int MIN_MS      = 16,
    parameter int MAX_MS      = 26,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       ms_tick,
    input  logic       vbus_sess_vld_i,
    input  logic       vbus_low_i,
    input  logic       line_se0_i,
    output logic       dline_pulse_o,
    output logic       vbus_pulse_o,
    output logic       vbus_dischg_o,
    output logic       vbus_sense_en_o,
    output logic       pw_err_o
);
    import srp_pkg::*;

    localparam int SENSE_W = $bits(srp_sense_t);
    // idle line: VBUS low, SE0 present, no session
    localparam logic [SENSE_W-1:0] SENSE_IDLE = 3'b110;

    srp_regs_t  regs_d, regs_q;
    srp_sense_t sense_raw, sense_s;
    logic       unused_wr_rsvd;

    assign unused_wr_rsvd = ^wr_data[REG_W-1:USED_W];

    assign sense_raw = '{se0: line_se0_i, vlow: vbus_low_i, sess: vbus_sess_vld_i};

    srp_sync #(
        .W       (SENSE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SENSE_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sense_raw),
        .sync_o  (sense_s)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d.en     = wr_data[BIT_EN];
            regs_d.vpulse = wr_data[BIT_VP];
            regs_d.dischg = wr_data[BIT_DIS];
            regs_d.dpulse = wr_data[BIT_DP];
            if (wr_data[BIT_INIT])  regs_d.init_v = 1'b0;
            if (wr_data[BIT_BSESS]) regs_d.bsess  = 1'b0;
        end
        // set conditions win over a same-cycle clear
        if (sense_s.sess)                   regs_d.bsess  = 1'b1;
        if (!sense_s.vlow || !sense_s.se0)  regs_d.init_v = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data         = {{(REG_W-USED_W){1'b0}}, regs_q};
    assign dline_pulse_o   = regs_q.en & regs_q.dpulse;
    assign vbus_pulse_o    = regs_q.en & regs_q.vpulse;
    assign vbus_dischg_o   = regs_q.en & regs_q.dischg;
    assign vbus_sense_en_o = ~regs_q.en;

    srp_pw_timer #(
        .MIN_MS (MIN_MS),
        .MAX_MS (MAX_MS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (vbus_pulse_o),
        .tick_i   (ms_tick),
        .err_o    (pw_err_o)
    );

endmodule

// File: rtl/srp_ctrl_reg_chk.sv
module srp_ctrl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       vbus_sess_vld_i,
    input logic       dline_pulse_o,
    input logic       vbus_pulse_o,
    input logic       vbus_dischg_o,
    input logic       pw_err_o
);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[7:6] != 2'b00)) |=> (rd_data[7:6] == 2'b00));

    // R3
    en_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0]) |=> (!dline_pulse_o && !vbus_pulse_o && !vbus_dischg_o));

    // R4
    vp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0] && wr_data[1]) |=> vbus_pulse_o);

    // R6
    bsess_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && !(wr_en && wr_data[4])) |=> rd_data[4]);

    // R12
    pw_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_err_o && !vbus_pulse_o) |=> pw_err_o);

endmodule

bind srp_ctrl_reg srp_ctrl_reg_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .rd_data         (rd_data),
    .vbus_sess_vld_i (vbus_sess_vld_i),
    .dline_pulse_o   (dline_pulse_o),
    .vbus_pulse_o    (vbus_pulse_o),
    .vbus_dischg_o   (vbus_dischg_o),
    .pw_err_o        (pw_err_o)
);

// File: tb/srp_ctrl_reg_tb.sv
module srp_ctrl_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ms_tick = 1'b0;
    logic       sess = 1'b0;
    logic       vlow = 1'b1;
    logic       se0 = 1'b1;
    logic       dline, vpulse, dischg, sense_en, pw_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    srp_ctrl_reg dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .rd_data         (rd_data),
        .ms_tick         (ms_tick),
        .vbus_sess_vld_i (sess),
        .vbus_low_i      (vlow),
        .line_se0_i      (se0),
        .dline_pulse_o   (dline),
        .vbus_pulse_o    (vpulse),
        .vbus_dischg_o   (dischg),
        .vbus_sense_en_o (sense_en),
        .pw_err_o        (pw_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 drives", {5'b0, dline, vpulse, dischg}, 8'h00);
        chk("R1 sense_en", {7'b0, sense_en}, 8'h01);
        chk("R1 pw_err", {7'b0, pw_err}, 8'h00);
    endtask

    task automatic t_ctrl_bits();
        wr(8'hE7);
        chk("R2 readback reserved zero", rd_data, 8'h27);
        chk("R4 drives on", {5'b0, dline, vpulse, dischg}, 8'h07);
        chk("R3 sense_en off", {7'b0, sense_en}, 8'h00);
        wr(8'hE6);
        chk("R2 readback enable clear", rd_data, 8'h26);
        chk("R3 drives masked", {5'b0, dline, vpulse, dischg}, 8'h00);
        chk("R3 sense_en on", {7'b0, sense_en}, 8'h01);
        wr(8'h21);
        chk("R4 only dline", {5'b0, dline, vpulse, dischg}, 8'h04);
        wr(8'h05);
        chk("R4 only discharge", {5'b0, dline, vpulse, dischg}, 8'h01);
        wr(8'h01);
    endtask

    task automatic t_bsess();
        sess = 1'b1; idle(4);
        chk("R5 set", {7'b0, rd_data[4]}, 8'h01);
        sess = 1'b0; idle(4);
        chk("R5 sticky", {7'b0, rd_data[4]}, 8'h01);
        wr(8'h01);
        chk("R6 write zero keeps", {7'b0, rd_data[4]}, 8'h01);
        wr(8'h11);
        chk("R6 w1c clears", {7'b0, rd_data[4]}, 8'h00);
        sess = 1'b1; idle(4);
        wr(8'h11);
        chk("R7 reset while valid", {7'b0, rd_data[4]}, 8'h01);
        sess = 1'b0; idle(4);
        wr(8'h11);
        chk("R7 clear after drop", {7'b0, rd_data[4]}, 8'h00);
    endtask

    task automatic t_init();
        chk("R8 clear at start", {7'b0, rd_data[3]}, 8'h00);
        vlow = 1'b0; idle(4);
        chk("R8 set by vbus", {7'b0, rd_data[3]}, 8'h01);
        vlow = 1'b1; idle(4);
        chk("R8 sticky", {7'b0, rd_data[3]}, 8'h01);
        wr(8'h09);
        chk("R8 w1c", {7'b0, rd_data[3]}, 8'h00);
        se0 = 1'b0; idle(4);
        chk("R8 set by lines", {7'b0, rd_data[3]}, 8'h01);
        wr(8'h09);
        chk("R8 persists", {7'b0, rd_data[3]}, 8'h01);
        se0 = 1'b1; idle(4);
        wr(8'h09);
        chk("R8 clear after", {7'b0, rd_data[3]}, 8'h00);
    endtask

    task automatic pulse(input int n, input logic exp_err, input string tag);
        wr(8'h03);
        idle(1);
        ticks(n);
        wr(8'h01);
        idle(2);
        chk(tag, {7'b0, pw_err}, {7'b0, exp_err});
    endtask

    task automatic t_pw_window();
        pulse(10, 1'b1, "R9 short pulse");
        wr(8'h03); idle(2);
        chk("R12 cleared by new pulse", {7'b0, pw_err}, 8'h00);
        wr(8'h01); idle(2);
        pulse(16, 1'b1, "R9 pulse at minimum");
        pulse(17, 1'b0, "R10 just above minimum");
        pulse(20, 1'b0, "R10 mid window");
        pulse(25, 1'b0, "R10 just below maximum");
    endtask

    task automatic t_pw_long();
        wr(8'h03);
        idle(1);
        ticks(25);
        idle(1);
        chk("R11 not yet", {7'b0, pw_err}, 8'h00);
        ticks(1);
        idle(1);
        chk("R11 reached maximum", {7'b0, pw_err}, 8'h01);
        wr(8'h01);
        idle(5);
        chk("R12 sticky after end", {7'b0, pw_err}, 8'h01);
    endtask

    initial begin
        #15;
        t_reset();
        idle(2);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_ctrl_bits();
        t_bsess();
        t_init();
        t_pw_window();
        t_pw_long();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule